// File: doc/BRIEF.md
# Set 1 Keyboard Scan Code Decoder

This block turns a stream of Set 1 keyboard scan-code bytes into key events. The host side presents one byte per cycle in which `byte_valid` is high; the decoder watches for the extended prefix byte (0xE0) and for the two four-byte print-screen sequences. For every complete key code it emits a one-cycle event that carries a 7-bit key number, a flag saying whether the code was extended, and a flag saying whether the key went down or up.

Press and release are read from bit 7 of the byte that follows any prefix: clear means pressed, set means released. The prefix byte itself produces no event and marks only the byte after it as extended. Print screen goes down as E0 2A E0 37 and up as E0 B7 E0 AA. Each of these sequences is reported as one event, and the leading pair is held back until the decoder knows whether the matching trailing pair arrives. The decoder does not map keys to characters, does not track modifiers, and does not handle the pause key or the serial link from the keyboard.

Top module: `kbd_set1_decoder`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `ev_valid` is 0.
- R2: A non-prefix byte B received with no pending prefix and bit 7 clear produces, in the cycle after the strobe, `ev_valid`=1, `ev_code`=B[6:0], `ev_ext`=0, `ev_pressed`=1.
- R3: Such a byte with bit 7 set produces the same event but with `ev_pressed`=0.
- R4: A byte 0xE0 produces no event. The next non-prefix byte B (other than a print-screen lead) produces `ev_code`=B[6:0], `ev_ext`=1, `ev_pressed`=!B[7]. The extended flag then clears, so the byte after that is decoded as unprefixed.
- R5: Consecutive 0xE0 bytes produce no events and act as one prefix.
- R6: The sequence E0 2A E0 37 produces exactly one event, in the cycle after the 0x37 strobe: `ev_code`=0x37, `ev_ext`=1, `ev_pressed`=1. None of the first three bytes produces an event.
- R7: The sequence E0 B7 E0 AA produces exactly one event, in the cycle after the 0xAA strobe: `ev_code`=0x37, `ev_ext`=1, `ev_pressed`=0. None of the first three bytes produces an event.
- R8: If a pending E0 2A or E0 B7 is followed by a non-prefix byte, the pending pair is dropped and that byte is decoded as unprefixed (R2/R3).
- R9: If a pending pair is followed by 0xE0 and then a byte other than the expected tail (0x37 after 2A, 0xAA after B7), the pending pair is dropped and that byte is decoded as extended under R4. A lead byte (0x2A or 0xB7) in that position starts a new pending pair.
- R10: `ev_valid` is high only in the cycle right after a cycle with `byte_valid` high. Cycles with `byte_valid` low leave the decoding state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Strobe: `byte_in` holds a scan byte this cycle |
| byte_in | input | 8 | Scan-code byte |
| ev_valid | output | 1 | One-cycle key event strobe |
| ev_code | output | 7 | Key number (low seven bits of the final code byte) |
| ev_ext | output | 1 | Event came from a prefixed code |
| ev_pressed | output | 1 | 1 = key down, 0 = key up |

## Verification
The hardest states to reach are the abandoned print-screen cases. In these the decoder holds a lead pair, has seen a second prefix, and then gets a byte that is not the expected tail, possibly another lead. The bench drives these sequences byte by byte: E0 2A followed by a plain key, E0 2A E0 followed by an arrow key, and E0 B7 E0 2A E0 37, where a break lead is replaced by a make lead that then completes. It also inserts idle cycles inside a prefixed sequence to show that the held state survives gaps in the strobe.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_EXT      = 2'd1,
        ST_HOLD     = 2'd2,
        ST_HOLD_EXT = 2'd3
    } dec_state_e;

    typedef struct packed {
        dec_state_e state;
        logic       hold_brk;
        logic       ev_valid;
        logic [6:0] ev_code;
        logic       ev_ext;
        logic       ev_pressed;
    } dec_regs_t;

endpackage

// File: rtl/kbd_byte_class.sv
module kbd_byte_class #(
    parameter int          DATA_W    = 8,
    parameter logic [7:0]  PREFIX    = 8'hE0,
    parameter logic [7:0]  MK_LEAD   = 8'h2A,
    parameter logic [7:0]  MK_TAIL   = 8'h37,
    parameter logic [7:0]  BRK_LEAD  = 8'hB7,
    parameter logic [7:0]  BRK_TAIL  = 8'hAA
) (
    input  logic [DATA_W-1:0] byte_in,
    output logic              is_prefix,
    output logic              is_mk_lead,
    output logic              is_mk_tail,
    output logic              is_brk_lead,
    output logic              is_brk_tail
);
    always_comb begin
        is_prefix   = (byte_in == PREFIX[DATA_W-1:0]);
        is_mk_lead  = (byte_in == MK_LEAD[DATA_W-1:0]);
        is_mk_tail  = (byte_in == MK_TAIL[DATA_W-1:0]);
        is_brk_lead = (byte_in == BRK_LEAD[DATA_W-1:0]);
        is_brk_tail = (byte_in == BRK_TAIL[DATA_W-1:0]);
    end
endmodule

// File: rtl/kbd_seq_fsm.sv
module kbd_seq_fsm
    import kbd_pkg::*;
#(
    parameter int         DATA_W  = 8,
    parameter logic [7:0] MK_TAIL = 8'h37,
    localparam int        CODE_W  = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              is_prefix,
    input  logic              is_mk_lead,
    input  logic              is_mk_tail,
    input  logic              is_brk_lead,
    input  logic              is_brk_tail,
    output logic              ev_valid,
    output logic [CODE_W-1:0] ev_code,
    output logic              ev_ext,
    output logic              ev_pressed
);
    dec_regs_t r_d, r_q;

    // Emit a key event built from the current byte.
    function automatic dec_regs_t emit_byte(input dec_regs_t cur,
                                            input logic [DATA_W-1:0] b,
                                            input logic ext);
        dec_regs_t n = cur;
        n.state      = ST_IDLE;
        n.hold_brk   = 1'b0;
        n.ev_valid   = 1'b1;
        n.ev_code    = b[CODE_W-1:0];
        n.ev_ext     = ext;
        n.ev_pressed = ~b[DATA_W-1];
        return n;
    endfunction

    // Handling of a byte that follows a prefix.
    function automatic dec_regs_t after_prefix(input dec_regs_t cur,
                                               input logic [DATA_W-1:0] b,
                                               input logic pre,
                                               input logic mk_lead,
                                               input logic brk_lead);
        dec_regs_t n = cur;
        if (pre) begin
            n.state = ST_EXT;
        end else if (mk_lead) begin
            n.state    = ST_HOLD;
            n.hold_brk = 1'b0;
        end else if (brk_lead) begin
            n.state    = ST_HOLD;
            n.hold_brk = 1'b1;
        end else begin
            n = emit_byte(cur, b, 1'b1);
        end
        return n;
    endfunction

    always_comb begin
        r_d          = r_q;
        r_d.ev_valid = 1'b0;
        if (byte_valid) begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (is_prefix) r_d.state = ST_EXT;
                    else           r_d = emit_byte(r_d, byte_in, 1'b0);
                end
                ST_EXT: begin
                    r_d = after_prefix(r_d, byte_in, is_prefix, is_mk_lead, is_brk_lead);
                end
                ST_HOLD: begin
                    if (is_prefix) r_d.state = ST_HOLD_EXT;
                    else           r_d = emit_byte(r_d, byte_in, 1'b0);
                end
                ST_HOLD_EXT: begin
                    if (r_q.hold_brk ? is_brk_tail : is_mk_tail) begin
                        r_d.state      = ST_IDLE;
                        r_d.hold_brk   = 1'b0;
                        r_d.ev_valid   = 1'b1;
                        r_d.ev_code    = MK_TAIL[CODE_W-1:0];
                        r_d.ev_ext     = 1'b1;
                        r_d.ev_pressed = ~r_q.hold_brk;
                    end else begin
                        r_d.hold_brk = 1'b0;
                        r_d = after_prefix(r_d, byte_in, is_prefix, is_mk_lead, is_brk_lead);
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ev_valid   = r_q.ev_valid;
    assign ev_code    = r_q.ev_code;
    assign ev_ext     = r_q.ev_ext;
    assign ev_pressed = r_q.ev_pressed;
endmodule

// File: rtl/kbd_set1_decoder.sv
module kbd_set1_decoder #(
    parameter int         DATA_W   = 8,
    parameter logic [7:0] PREFIX   = 8'hE0,
    parameter logic [7:0] MK_LEAD  = 8'h2A,
    parameter logic [7:0] MK_TAIL  = 8'h37,
    parameter logic [7:0] BRK_LEAD = 8'hB7,
    parameter logic [7:0] BRK_TAIL = 8'hAA,
    localparam int        CODE_W   = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_in,
    output logic              ev_valid,
    output logic [CODE_W-1:0] ev_code,
    output logic              ev_ext,
    output logic              ev_pressed
);
    logic c_pre, c_mk_lead, c_mk_tail, c_brk_lead, c_brk_tail;

    kbd_byte_class #(
        .DATA_W(DATA_W), .PREFIX(PREFIX), .MK_LEAD(MK_LEAD), .MK_TAIL(MK_TAIL),
        .BRK_LEAD(BRK_LEAD), .BRK_TAIL(BRK_TAIL)
    ) u_class (
        .byte_in    (byte_in),
        .is_prefix  (c_pre),
        .is_mk_lead (c_mk_lead),
        .is_mk_tail (c_mk_tail),
        .is_brk_lead(c_brk_lead),
        .is_brk_tail(c_brk_tail)
    );

    kbd_seq_fsm #(
        .DATA_W(DATA_W), .MK_TAIL(MK_TAIL)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .is_prefix  (c_pre),
        .is_mk_lead (c_mk_lead),
        .is_mk_tail (c_mk_tail),
        .is_brk_lead(c_brk_lead),
        .is_brk_tail(c_brk_tail),
        .ev_valid   (ev_valid),
        .ev_code    (ev_code),
        .ev_ext     (ev_ext),
        .ev_pressed (ev_pressed)
    );
endmodule

// File: rtl/kbd_set1_decoder_chk.sv
module kbd_set1_decoder_chk #(
    parameter int         DATA_W  = 8,
    parameter logic [7:0] PREFIX  = 8'hE0,
    parameter logic [7:0] MK_TAIL = 8'h37,
    localparam int        CODE_W  = DATA_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_valid,
    input logic [DATA_W-1:0] byte_in,
    input logic              ev_valid,
    input logic [CODE_W-1:0] ev_code,
    input logic              ev_ext,
    input logic              ev_pressed
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !ev_valid);

    // R10
    event_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> $past(byte_valid));

    // R5
    prefix_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(byte_valid && byte_in == PREFIX[DATA_W-1:0]) |-> !ev_valid);

    // R2
    plain_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ext) |-> (ev_code == $past(byte_in[CODE_W-1:0])
                                   && ev_pressed == !$past(byte_in[DATA_W-1])));

    // R4
    ext_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ext) |-> (ev_pressed == !$past(byte_in[DATA_W-1])
                                  && (ev_code == $past(byte_in[CODE_W-1:0])
                                      || ev_code == MK_TAIL[CODE_W-1:0])));
endmodule

bind kbd_set1_decoder kbd_set1_decoder_chk #(
    .DATA_W(DATA_W), .PREFIX(PREFIX), .MK_TAIL(MK_TAIL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
    .ev_valid(ev_valid), .ev_code(ev_code), .ev_ext(ev_ext), .ev_pressed(ev_pressed)
);

// File: tb/tb_kbd_set1_decoder.sv
module tb_kbd_set1_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       ev_valid;
    logic [6:0] ev_code;
    logic       ev_ext;
    logic       ev_pressed;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    kbd_set1_decoder dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
        .ev_valid(ev_valid), .ev_code(ev_code), .ev_ext(ev_ext), .ev_pressed(ev_pressed)
    );

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got valid/code/ext/pressed=%h expected %h", req, act, exp);
        end
    endtask

    // Present one byte, then check the registered output one cycle later.
    task automatic send_silent(input logic [7:0] b, input string req);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = b;
        @(negedge clk);
        byte_valid = 1'b0;
        check(req, {ev_valid, 9'd0}, 10'd0);
    endtask

    task automatic send_ev(input logic [7:0] b, input logic [6:0] code,
                           input logic ext, input logic pr, input string req);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = b;
        @(negedge clk);
        byte_valid = 1'b0;
        check(req, {ev_valid, ev_code, ev_ext, ev_pressed}, {1'b1, code, ext, pr});
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, {ev_valid, 9'd0}, 10'd0);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", {ev_valid, 9'd0}, 10'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {ev_valid, 9'd0}, 10'd0);
    endtask

    task automatic t_plain;
        send_ev(8'h1E, 7'h1E, 1'b0, 1'b1, "R2");
        send_ev(8'h9E, 7'h1E, 1'b0, 1'b0, "R3");
        send_ev(8'h01, 7'h01, 1'b0, 1'b1, "R2");
        send_ev(8'hFF, 7'h7F, 1'b0, 1'b0, "R3");
    endtask

    task automatic t_extended;
        send_silent(8'hE0, "R4");
        send_ev(8'h4B, 7'h4B, 1'b1, 1'b1, "R4");
        send_silent(8'hE0, "R4");
        send_ev(8'hCB, 7'h4B, 1'b1, 1'b0, "R4");
        send_ev(8'h4B, 7'h4B, 1'b0, 1'b1, "R4 flag cleared");
        send_silent(8'hE0, "R5");
        send_silent(8'hE0, "R5");
        send_silent(8'hE0, "R5");
        send_ev(8'h48, 7'h48, 1'b1, 1'b1, "R5");
    endtask

    task automatic t_prtsc;
        send_silent(8'hE0, "R6");
        send_silent(8'h2A, "R6");
        send_silent(8'hE0, "R6");
        send_ev(8'h37, 7'h37, 1'b1, 1'b1, "R6");
        idle(1, "R6 single pulse");
        send_silent(8'hE0, "R7");
        send_silent(8'hB7, "R7");
        send_silent(8'hE0, "R7");
        send_ev(8'hAA, 7'h37, 1'b1, 1'b0, "R7");
        idle(1, "R7 single pulse");
    endtask

    task automatic t_abandon;
        send_silent(8'hE0, "R8");
        send_silent(8'h2A, "R8");
        send_ev(8'h1E, 7'h1E, 1'b0, 1'b1, "R8");
        send_silent(8'hE0, "R8");
        send_silent(8'hB7, "R8");
        send_ev(8'hAA, 7'h2A, 1'b0, 1'b0, "R8");
        send_silent(8'hE0, "R9");
        send_silent(8'h2A, "R9");
        send_silent(8'hE0, "R9");
        send_ev(8'h4B, 7'h4B, 1'b1, 1'b1, "R9");
        send_silent(8'hE0, "R9");
        send_silent(8'h2A, "R9");
        send_silent(8'hE0, "R9");
        send_ev(8'hAA, 7'h2A, 1'b1, 1'b0, "R9 wrong tail");
        send_silent(8'hE0, "R9");
        send_silent(8'hB7, "R9");
        send_silent(8'hE0, "R9");
        send_silent(8'h2A, "R9 new lead");
        send_silent(8'hE0, "R9");
        send_ev(8'h37, 7'h37, 1'b1, 1'b1, "R9 new lead done");
        send_ev(8'h10, 7'h10, 1'b0, 1'b1, "R9 back to plain");
    endtask

    task automatic t_gaps;
        send_silent(8'hE0, "R10");
        idle(4, "R10");
        send_ev(8'h53, 7'h53, 1'b1, 1'b1, "R10");
        send_silent(8'hE0, "R10");
        send_silent(8'h2A, "R10");
        idle(3, "R10");
        send_silent(8'hE0, "R10");
        idle(2, "R10");
        send_ev(8'h37, 7'h37, 1'b1, 1'b1, "R10");
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_plain();
        t_extended();
        t_prtsc();
        t_abandon();
        t_gaps();
        idle(2, "R10");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule